// File: doc/BRIEF.md
# ALU with Two-Level Operation Decode

This block is the arithmetic-logic unit of a multicycle processor, paired with the small decoder that chooses its operation. The main sequencer does not name the ALU operation itself. It supplies a 2-bit operation class. For register-format instructions it also passes the 6-bit function field of the instruction. The decoder combines the two into an internal operation: add, subtract, AND, OR or signed set-less-than. The ALU then applies that operation to two 32-bit operands.

The block has no clock and no state. The result and the zero flag follow the inputs in the same cycle. The sequencer uses the zero flag to decide whether the program counter is updated on a branch-equal. That comparison is a subtraction forced by the operation class. A fourth class forces a bitwise OR for OR-immediate, so this class does not depend on the function field.

Top module: `alu_ctl_top`

## Requirements
- R1: Operation class 2'b00 produces opnd_a + opnd_b modulo 2^32, whatever value funct holds.
- R2: Operation class 2'b01 produces opnd_a - opnd_b modulo 2^32, whatever value funct holds.
- R3: With class 2'b10, funct 6'b100000 selects add and funct 6'b100010 selects subtract.
- R4: With class 2'b10, funct 6'b100100 selects bitwise AND and funct 6'b100101 selects bitwise OR.
- R5: With class 2'b10, funct 6'b101010 compares the operands as signed two's-complement numbers. The result is 32'd1 when opnd_a < opnd_b and 32'd0 otherwise. The comparison stays correct when the subtraction opnd_a - opnd_b overflows.
- R6: With class 2'b10, any funct code other than the four listed in R3 and R4 and the one in R5 selects add.
- R7: Operation class 2'b11 produces opnd_a | opnd_b, whatever value funct holds.
- R8: zero is 1 exactly when all 32 bits of result are 0.
- R9: result and zero depend only on the present inputs. There is no clock and no retained state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class | input | 2 | Operation class from the main sequencer |
| funct | input | 6 | Function field of the instruction |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| result | output | 32 | ALU result |
| zero | output | 1 | High when result is all zeros |

## Verification
The block holds no state, so any wrong internal value appears at result or zero in the same cycle that the inputs select it. A decoder that maps a class or function code to the wrong operation changes result for almost any operand pair. The bench therefore sweeps every class, the fixed codes and several unlisted codes over varied operands. An error in overflow handling shows only when the operands have opposite signs and their difference overflows, so the bench drives those extreme pairs on purpose. A zero flag that does not track result is exposed by equal-operand subtractions and by operand pairs whose AND is zero.

// File: rtl/alu_ctl_pkg.sv
package alu_ctl_pkg;
  localparam int unsigned CLASS_W = 2;
  localparam int unsigned FN_W    = 6;

  localparam logic [CLASS_W-1:0] CLS_ADD = 2'b00;
  localparam logic [CLASS_W-1:0] CLS_SUB = 2'b01;
  localparam logic [CLASS_W-1:0] CLS_FN  = 2'b10;
  localparam logic [CLASS_W-1:0] CLS_OR  = 2'b11;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_AND = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_SLT = 3'd4
  } alu_op_e;

  // The adder also serves subtract and compare.
  function automatic logic op_needs_sub(alu_op_e op);
    return (op == OP_SUB) || (op == OP_SLT);
  endfunction
endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_ctl_pkg::*;
(
  input  logic [CLASS_W-1:0] op_class,
  input  logic [FN_W-1:0]    funct,
  output alu_op_e            alu_op
);
  alu_op_e fn_op;

  // Second level: the function field, consulted only for class CLS_FN.
  always_comb begin
    unique case (funct)
      FN_SUB:  fn_op = OP_SUB;
      FN_AND:  fn_op = OP_AND;
      FN_OR:   fn_op = OP_OR;
      FN_SLT:  fn_op = OP_SLT;
      default: fn_op = OP_ADD;
    endcase
  end

  // First level: the class from the sequencer.
  always_comb begin
    unique case (op_class)
      CLS_ADD: alu_op = OP_ADD;
      CLS_SUB: alu_op = OP_SUB;
      CLS_FN:  alu_op = fn_op;
      default: alu_op = OP_OR;
    endcase
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf,
  output logic         less
);
  logic [W-1:0] b_eff;

  function automatic logic [W-1:0] add_w(logic [W-1:0] x, logic [W-1:0] y, logic cin);
    return x + y + {{(W-1){1'b0}}, cin};
  endfunction

  assign b_eff = sub ? ~b : b;
  assign sum   = add_w(a, b_eff, sub);
  // Signed overflow: the inputs to the adder share a sign that the sum does not.
  assign ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  // a < b signed: the sign of a - b, corrected when it overflowed.
  assign less  = sum[W-1] ^ ovf;
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_ctl_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  alu_op_e      alu_op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         ovf,
  output logic         less
);
  logic [W-1:0] sum;

  alu_addsub #(.W(W)) u_addsub (
    .a    (a),
    .b    (b),
    .sub  (op_needs_sub(alu_op)),
    .sum  (sum),
    .ovf  (ovf),
    .less (less)
  );

  always_comb begin
    unique case (alu_op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_SLT:  y = {{(W-1){1'b0}}, less};
      default: y = sum;
    endcase
  end
endmodule

// File: rtl/alu_ctl_top.sv
module alu_ctl_top
  import alu_ctl_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [1:0]   op_class,
  input  logic [5:0]   funct,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] result,
  output logic         zero
);
  alu_op_e alu_op;
  logic    add_ovf;
  logic    lt_flag;

  alu_op_decode u_dec (
    .op_class (op_class),
    .funct    (funct),
    .alu_op   (alu_op)
  );

  alu_core #(.W(W)) u_core (
    .alu_op (alu_op),
    .a      (opnd_a),
    .b      (opnd_b),
    .y      (result),
    .ovf    (add_ovf),
    .less   (lt_flag)
  );

  assign zero = ~|result;
endmodule

// File: rtl/alu_ctl_checker.sv
module alu_ctl_checker
  import alu_ctl_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic [1:0]   op_class,
  input logic [5:0]   funct,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [W-1:0] result,
  input logic         zero,
  input alu_op_e      alu_op,
  input logic         add_ovf,
  input logic         lt_flag
);
  always_comb begin
    if (!$isunknown({op_class, funct, opnd_a, opnd_b})) begin
      // R1: class 00 decodes to add for any funct
      a_r1_class_add: assert (op_class != CLS_ADD || alu_op == OP_ADD)
        else $error("R1 decode");
      // R2: branch compare drives zero from operand equality
      a_r2_beq_zero: assert (op_class != CLS_SUB || zero == (opnd_a == opnd_b))
        else $error("R2 zero");
      // R7: class 11 yields OR at the result port
      a_r7_class_or: assert (op_class != CLS_OR || result == (opnd_a | opnd_b))
        else $error("R7 or");
      // R5: compare result is a single bit, zero-extended
      a_r5_slt_width: assert (alu_op != OP_SLT || result[W-1:1] == '0)
        else $error("R5 width");
      // R5: overflow only when operand signs differ during compare
      a_r5_ovf_sign: assert (alu_op != OP_SLT || !add_ovf || opnd_a[W-1] != opnd_b[W-1])
        else $error("R5 ovf");
      // R5: when signs differ, a < b exactly when a is negative
      a_r5_slt_sign: assert (alu_op != OP_SLT || opnd_a[W-1] == opnd_b[W-1]
                             || lt_flag == opnd_a[W-1])
        else $error("R5 sign");
      // R6: unlisted function codes fall back to add
      a_r6_default: assert (op_class != CLS_FN || funct == FN_SUB || funct == FN_AND
                            || funct == FN_OR || funct == FN_SLT || alu_op == OP_ADD)
        else $error("R6 default");
    end
  end
endmodule

bind alu_ctl_top alu_ctl_checker #(.W(W)) u_chk (
  .op_class (op_class),
  .funct    (funct),
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .result   (result),
  .zero     (zero),
  .alu_op   (alu_op),
  .add_ovf  (add_ovf),
  .lt_flag  (lt_flag)
);

// File: tb/alu_ctl_top_bench.sv
module alu_ctl_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op_class;
  logic [5:0]  funct;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic [31:0] result;
  logic        zero;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  alu_ctl_top u_alu_ctl_top (
    .op_class (op_class),
    .funct    (funct),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .result   (result),
    .zero     (zero)
  );

  // Behavioural reference, written from the requirements.
  function automatic logic [31:0] ref_model(logic [1:0] c, logic [5:0] f,
                                            logic [31:0] a, logic [31:0] b);
    longint sa, sb;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (c == 2'b00) return a + b;
    if (c == 2'b01) return a - b;
    if (c == 2'b11) return a | b;
    if (f == 6'd32) return a + b;
    if (f == 6'd34) return a - b;
    if (f == 6'd36) return a & b;
    if (f == 6'd37) return a | b;
    if (f == 6'd42) return (sa < sb) ? 32'd1 : 32'd0;
    return a + b;
  endfunction

  task automatic apply(input logic [1:0] c, input logic [5:0] f,
                       input logic [31:0] a, input logic [31:0] b, input string req);
    logic [31:0] exp_y;
    @(posedge clk);
    #2;
    op_class = c; funct = f; opnd_a = a; opnd_b = b;
    exp_y = ref_model(c, f, a, b);
    @(negedge clk);
    checks++;
    if (result !== exp_y) begin
      errors++;
      $display("FAIL %s result cls=%b fn=%b a=%h b=%h actual %h expected %h",
               req, c, f, a, b, result, exp_y);
    end
    checks++;
    if (zero !== (exp_y == 32'd0)) begin
      errors++;
      $display("FAIL R8 zero (%s) actual %b expected %b", req, zero, exp_y == 32'd0);
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    op_class = 2'b00; funct = '0; opnd_a = '0; opnd_b = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // Initial state: all-zero inputs give result 0 and zero high (R8, R9)
    @(negedge clk);
    checks++;
    if (result !== 32'd0 || zero !== 1'b1) begin
      errors++;
      $display("FAIL R9 idle actual %h/%b expected 0/1", result, zero);
    end
    // R1: add ignores funct
    apply(2'b00, 6'b100010, 32'h0000_0005, 32'h0000_0003, "R1");
    apply(2'b00, 6'b100100, 32'hFFFF_FFFF, 32'h0000_0001, "R1");
    // R2: subtract, equal operands give zero
    apply(2'b01, 6'b100000, 32'h1234_5678, 32'h1234_5678, "R2");
    apply(2'b01, 6'b100101, 32'h0000_0001, 32'h0000_0002, "R2");
    // R3
    apply(2'b10, 6'b100000, 32'h7FFF_FFFF, 32'h0000_0001, "R3");
    apply(2'b10, 6'b100010, 32'h0000_0010, 32'h0000_0011, "R3");
    // R4
    apply(2'b10, 6'b100100, 32'hF0F0_F0F0, 32'h0F0F_0F0F, "R4");
    apply(2'b10, 6'b100101, 32'hF0F0_0000, 32'h0000_0F0F, "R4");
    // R5 signed compare incl. overflow of a - b
    apply(2'b10, 6'b101010, 32'hFFFF_FFFF, 32'h0000_0001, "R5");
    apply(2'b10, 6'b101010, 32'h0000_0001, 32'hFFFF_FFFF, "R5");
    apply(2'b10, 6'b101010, 32'h8000_0000, 32'h7FFF_FFFF, "R5");
    apply(2'b10, 6'b101010, 32'h7FFF_FFFF, 32'h8000_0000, "R5");
    apply(2'b10, 6'b101010, 32'h0000_0007, 32'h0000_0007, "R5");
    // R6 unlisted codes
    apply(2'b10, 6'b000000, 32'h0000_0100, 32'h0000_0200, "R6");
    apply(2'b10, 6'b100111, 32'h0000_00FF, 32'h0000_0F00, "R6");
    apply(2'b10, 6'b101011, 32'h8000_0000, 32'h7FFF_FFFF, "R6");
    // R7 OR ignores funct
    apply(2'b11, 6'b100100, 32'hA5A5_0000, 32'h0000_5A5A, "R7");
    apply(2'b11, 6'b101010, 32'h0000_0000, 32'h0000_0000, "R7");
    // Sweep of mixed patterns (R9: every cycle is independent)
    for (int i = 0; i < 400; i++) begin
      logic [1:0]  c;
      logic [5:0]  f;
      logic [31:0] a, b;
      c = 2'($urandom);
      f = (i % 3 == 0) ? 6'($urandom) : 6'(32 + 2 * ($urandom % 6));
      a = $urandom;
      b = (i % 7 == 0) ? a : $urandom;
      apply(c, f, a, b, "R9");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule